// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is one 32-bit timer channel. Once enabled it loads a programmable reload value and counts down by one on every decrement step. When it is at zero, the next step loads the reload value again. A control bit sets where the steps come from. With the bit at 0 the counter steps on every bus clock cycle. With the bit at 1 it steps only on cycles where an external 1 MHz tick strobe is high.

Two match values are compared against the count as it steps down. A third event source is the count landing on zero. Every cycle that carries at least one event inverts the interrupt level output. The output is a toggling level, not a pulse, so an interrupt controller detects events by watching for edges on it.

A match value that is not below the reload value never schedules an event of its own. Software can also overwrite the live count while the channel runs, and counting goes on from the value written. Address decoding and pulse-output generation belong to the surrounding logic. The reload and match values arrive already stored, and the surrounding logic clears them on reset.

Top module: `dmt_channel`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, count is zero and irq_level is zero. Nothing changes until run_en is raised.
- R2: A decrement step with count not zero makes count one less on the next cycle. A step with count at zero loads reload_val, so one period spans reload_val+1 steps.
- R3: With tick_src_ext=0 every enabled cycle is a step. With tick_src_ext=1 only enabled cycles with ext_tick=1 are steps, and the count holds on the other cycles.
- R4: A match value that is greater than or equal to reload_val never raises a match event.
- R5: A cycle with one or more events inverts irq_level exactly once on the next edge, even when several events coincide. A cycle without events leaves irq_level unchanged.
- R6: A match event is raised when a step brings the count down onto a non-zero match value that is below reload_val. With two such values, the larger one fires first in a period and the smaller one fires later, each once per period.
- R7: A step that brings the count from 1 to 0 raises an event when wrap_irq_en=1, or when either match input is zero. Otherwise that step raises no event.
- R8: A cycle in which run_en is high after being low loads reload_val into count and does not decrement. While run_en is low, count and irq_level hold.
- R9: A pulse on cnt_wr while the channel runs (not on its start cycle) sets count to cnt_wr_data on the next cycle and raises no event. Counting then continues from that value. The write takes precedence over a step in the same cycle.
- R10: A pulse on cnt_wr while run_en is low is ignored, and count keeps its value.
- R11: With reload_val=0 the count stays at zero and no steady stream of events is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | One-cycle strobe of the external 1 MHz tick |
| run_en | input | 1 | Channel enable |
| tick_src_ext | input | 1 | Step source select: 1 = external tick, 0 = every bus clock |
| wrap_irq_en | input | 1 | Raise an event when the count reaches zero |
| reload_val | input | 32 | Reload value |
| match_a | input | 32 | First match value |
| match_b | input | 32 | Second match value |
| cnt_wr | input | 1 | Direct count write strobe |
| cnt_wr_data | input | 32 | Value for a direct count write |
| count | output | 32 | Live count |
| irq_level | output | 1 | Interrupt level, inverted on each event cycle |

## Verification
The assertions check on every cycle that irq_level moves only on event cycles and by exactly one inversion. They also check that a match event needs its value to lie below the reload value, that a zero reload stays silent, and that the external tick gates steps. They cover the start, wrap, write and hold rules of the counter as well. Only the bench scenarios can show the whole-period behaviour: the larger match firing before the smaller one, one event per match per period, and the zero-event rule under each combination of its conditions. The same applies to writes landing on exactly the cycles the requirements name.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  localparam int unsigned DMT_WIDTH = 32;

  // What the counter does on the coming edge
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_START = 2'd1,
    ACT_WRITE = 2'd2,
    ACT_STEP  = 2'd3
  } dmt_act_e;

endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel
  import dmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_en,
  input  logic     tick_src_ext,
  input  logic     ext_tick,
  input  logic     cnt_wr,
  output dmt_act_e act
);

  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end

  function automatic logic step_ok(input logic src_ext, input logic tick);
    return src_ext ? tick : 1'b1;
  endfunction

  // Priority: start, then write, then step
  always_comb begin
    if (!run_en)                        act = ACT_IDLE;
    else if (!run_q)                    act = ACT_START;
    else if (cnt_wr)                    act = ACT_WRITE;
    else if (step_ok(tick_src_ext, ext_tick)) act = ACT_STEP;
    else                                act = ACT_IDLE;
  end

  AST_EXT_TICK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && tick_src_ext) |-> ext_tick) else $error("step without tick"); // R3
  AST_OFF_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> act == ACT_IDLE) else $error("action while disabled"); // R8

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
  import dmt_pkg::*;
#(
  parameter int unsigned W = DMT_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dmt_act_e     act,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic [W-1:0] next_val,
  output logic         dec_fire
);

  function automatic logic [W-1:0] minus_one(input logic [W-1:0] v);
    return v - {{(W-1){1'b0}}, 1'b1};
  endfunction

  assign next_val = minus_one(count);
  assign dec_fire = (act == ACT_STEP) && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      unique case (act)
        ACT_START: count <= reload_val;
        ACT_WRITE: count <= wr_data;
        ACT_STEP:  count <= (count == '0) ? reload_val : next_val;
        default:   count <= count;
      endcase
    end
  end

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && count == '0) |=> count == $past(reload_val)) else $error("wrap"); // R2
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> count == $past(count) - 1) else $error("decrement"); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_WRITE) |=> count == $past(wr_data)) else $error("write"); // R9
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_START) |=> count == $past(reload_val)) else $error("start"); // R8

endmodule

// File: rtl/dmt_match_unit.sv
module dmt_match_unit #(
  parameter int unsigned W       = 32,
  parameter int unsigned N_MATCH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_MATCH-1:0][W-1:0]     match_vec,
  input  logic [W-1:0]                  reload_val,
  input  logic [W-1:0]                  next_val,
  input  logic                          dec_fire,
  input  logic                          wrap_irq_en,
  output logic [N_MATCH-1:0]            hit,
  output logic                          zero_evt,
  output logic                          any_evt
);

  // A match at or above reload schedules nothing of its own
  function automatic logic [W-1:0] eff_match(input logic [W-1:0] m, input logic [W-1:0] r);
    return (m < r) ? m : '0;
  endfunction

  for (genvar gi = 0; gi < N_MATCH; gi++) begin : g_cmp
    logic [W-1:0] eff;
    assign eff     = eff_match(match_vec[gi], reload_val);
    assign hit[gi] = dec_fire && (eff != '0) && (next_val == eff);

    AST_MATCH_BELOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hit[gi] |-> match_vec[gi] < reload_val) else $error("match not below reload"); // R4
  end

  logic raw_zero;
  always_comb begin
    raw_zero = 1'b0;
    for (int i = 0; i < N_MATCH; i++) raw_zero = raw_zero | (match_vec[i] == '0);
  end

  assign zero_evt = dec_fire && (next_val == '0) && (wrap_irq_en || raw_zero);
  assign any_evt  = (|hit) || zero_evt;

  AST_ZERO_COND: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (wrap_irq_en || raw_zero)) else $error("zero event"); // R7

endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int unsigned W = DMT_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_tick,
  input  logic         run_en,
  input  logic         tick_src_ext,
  input  logic         wrap_irq_en,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] match_a,
  input  logic [W-1:0] match_b,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wr_data,
  output logic [W-1:0] count,
  output logic         irq_level
);

  localparam int unsigned N_MATCH = 2;

  dmt_act_e                      act;
  logic [W-1:0]                  next_val;
  logic                          dec_fire;
  logic [N_MATCH-1:0][W-1:0]     match_vec;
  logic [N_MATCH-1:0]            hit;
  logic                          zero_evt;
  logic                          any_evt;

  assign match_vec = {match_b, match_a};

  dmt_tick_sel i_tick_sel (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_src_ext(tick_src_ext),
    .ext_tick(ext_tick), .cnt_wr(cnt_wr), .act(act)
  );

  dmt_counter #(.W(W)) i_counter (
    .clk(clk), .rst_n(rst_n), .act(act), .reload_val(reload_val),
    .wr_data(cnt_wr_data), .count(count), .next_val(next_val), .dec_fire(dec_fire)
  );

  dmt_match_unit #(.W(W), .N_MATCH(N_MATCH)) i_match (
    .clk(clk), .rst_n(rst_n), .match_vec(match_vec), .reload_val(reload_val),
    .next_val(next_val), .dec_fire(dec_fire), .wrap_irq_en(wrap_irq_en),
    .hit(hit), .zero_evt(zero_evt), .any_evt(any_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_level <= 1'b0;
    else if (any_evt) irq_level <= ~irq_level;
  end

  AST_IRQ_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> irq_level != $past(irq_level)) else $error("no flip"); // R5
  AST_IRQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(irq_level)) else $error("spurious flip"); // R5
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(count) && $stable(irq_level)) else $error("moved while off"); // R8
  AST_ZERO_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_val == '0 && count == '0) |-> !any_evt) else $error("zero reload event"); // R11
  AST_WRITE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_WRITE) |-> !any_evt) else $error("event on write"); // R9

endmodule

// File: tb/test_dmt_channel.sv
module test_dmt_channel;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0, run_en = 1'b0, tick_src_ext = 1'b0, wrap_irq_en = 1'b0;
  logic [31:0] reload_val = '0, match_a = '0, match_b = '0, cnt_wr_data = '0;
  logic        cnt_wr = 1'b0;
  logic [31:0] count;
  logic        irq_level;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmt_channel i_dmt_channel (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .run_en(run_en),
    .tick_src_ext(tick_src_ext), .wrap_irq_en(wrap_irq_en), .reload_val(reload_val),
    .match_a(match_a), .match_b(match_b), .cnt_wr(cnt_wr), .cnt_wr_data(cnt_wr_data),
    .count(count), .irq_level(irq_level)
  );

  // Reference: does landing on value v raise an event?
  function automatic bit lands_on_event(input logic [31:0] v);
    if (v == 0) return wrap_irq_en || match_a == 0 || match_b == 0;
    return (match_a < reload_val && v == match_a) || (match_b < reload_val && v == match_b);
  endfunction

  logic [31:0] m_cnt;
  logic        m_irq, m_was_on;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_irq <= 0; m_was_on <= 0;
    end else begin
      m_was_on <= run_en;
      if (run_en) begin
        if (!m_was_on) m_cnt <= reload_val;
        else if (cnt_wr) m_cnt <= cnt_wr_data;
        else if (!tick_src_ext || ext_tick) begin
          if (m_cnt == 0) m_cnt <= reload_val;
          else begin
            m_cnt <= m_cnt - 1;
            if (lands_on_event(m_cnt - 1)) m_irq <= ~m_irq;
          end
        end
      end
    end
  end

  task automatic expect32(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One edge, then compare outputs with the reference at the falling edge
  task automatic cyc_chk(input string tag);
    @(posedge clk);
    @(negedge clk);
    expect32({tag, " count"}, count, m_cnt);
    expect32({tag, " irq"}, {31'd0, irq_level}, {31'd0, m_irq});
  endtask

  task automatic run_n(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc_chk(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic        irq_hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    expect32("R1 count in reset", count, 0);
    expect32("R1 irq in reset", {31'd0, irq_level}, 0);
    rst_n = 1'b1;
    run_n(3, "R1 idle after reset");
    expect32("R1 count idle", count, 0);

    // R8 / R2 / R6: reload 5, matches 3 and 1, every clock
    reload_val = 5; match_a = 1; match_b = 3; wrap_irq_en = 0;
    run_en = 1;
    cyc_chk("R8 start");
    expect32("R8 start loads reload", count, 5);
    run_n(2, "R6 larger match");
    expect32("R6 count at larger", count, 3);
    expect32("R6 irq after larger", {31'd0, irq_level}, 1);
    run_n(2, "R6 smaller match");
    expect32("R6 irq after smaller", {31'd0, irq_level}, 0);
    cyc_chk("R7 zero quiet");
    expect32("R7 no zero event", {31'd0, irq_level}, 0);
    cyc_chk("R2 wrap");
    expect32("R2 wrap to reload", count, 5);
    run_n(12, "R2 periods");

    // R7 zero rule variants
    wrap_irq_en = 1;
    run_n(14, "R7 overflow enabled");
    wrap_irq_en = 0; match_a = 0;
    run_n(14, "R7 raw zero match");

    // R4: matches at and above reload never fire; zero rule off
    match_a = 9; match_b = 5;
    run_n(2, "R4 settle");
    irq_hold = irq_level;
    run_n(14, "R4 inert matches");
    expect32("R4 irq untouched", {31'd0, irq_level}, {31'd0, irq_hold});

    // R5: coincident matches flip once
    match_a = 2; match_b = 2;
    run_n(14, "R5 coincident");

    // R3: external tick every fourth cycle
    match_a = 3; match_b = 1; tick_src_ext = 1;
    for (int k = 0; k < 40; k++) begin
      ext_tick = (k % 4 == 0);
      cyc_chk("R3 external tick");
    end
    ext_tick = 0; tick_src_ext = 0;

    // R9: write while running
    cnt_wr = 1; cnt_wr_data = 4;
    cyc_chk("R9 write");
    cnt_wr = 0;
    expect32("R9 write lands", count, 4);
    run_n(8, "R9 continue");

    // R10: write while disabled is ignored
    run_en = 0;
    cyc_chk("R8 disable");
    held = count;
    cnt_wr = 1; cnt_wr_data = 2;
    cyc_chk("R10 ignored write");
    cnt_wr = 0;
    run_n(3, "R10 hold");
    expect32("R10 count kept", count, held);

    // R11: zero reload
    reload_val = 0; wrap_irq_en = 1; match_a = 0;
    run_en = 1;
    run_n(2, "R11 start");
    irq_hold = irq_level;
    run_n(20, "R11 quiet");
    expect32("R11 count zero", count, 0);
    expect32("R11 irq steady", {31'd0, irq_level}, {31'd0, irq_hold});

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 150 == 0) begin
        reload_val = $urandom % 21; match_a = $urandom % 25; match_b = $urandom % 25;
        wrap_irq_en = $urandom % 2; tick_src_ext = $urandom % 2;
      end
      if ($urandom % 120 == 0) run_en = ~run_en;
      ext_tick    = ($urandom % 3 == 0);
      cnt_wr      = ($urandom % 60 == 0);
      cnt_wr_data = $urandom % 26;
      cyc_chk("R2 R6 random");
    end
    cnt_wr = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule